// File: doc/BRIEF.md
# Clocked Read/Write Bus Handshake Sequencer

This block sits between a parallel bus master and a local peripheral that is reached through a data transceiver. The master asks for a transfer by raising one of two strobes, one for reads and one for writes. The block then runs a four-phase handshake on its local side. It raises the device strobe, waits for the device acknowledge, and drives the transceiver enable. It then answers the master with a bus acknowledge. When the master releases its strobe, the block takes its own signals back to zero. Reads and writes use different orderings of the same three outputs. Both return to a common idle state in which every signal is low.

All three inputs are asynchronous to the clock. Each one passes through a chain of `SYNC_STAGES` flip-flops before the state machine sees it. The machine moves at most one handshake step per clock. The one exception is the release step, where the device strobe and the bus acknowledge fall together. The read path keeps a phase bit. It is set only once the synchronised acknowledge has been seen low while the read strobe is high, and it is cleared when the read strobe falls. This bit separates the point before the device has answered from the point after it has answered, even though the pins carry the same values at both points.

`SAFE_MODE` picks how a cycle ends:
- **Safe mode (1):** after the master releases its strobe, the machine waits in a release state until the device acknowledge is low.
- **Fast mode (0):** the machine returns to idle at once. It relies on the device dropping its acknowledge before the next request. If that assumption is broken, the machine flags it.

Any out-of-order input sets a sticky error output. Only reset clears it.

States:
- `ST_IDLE`: all outputs low.
- Read path: `ST_RD_STB` (strobe), `ST_RD_XCV` (strobe and enable), `ST_RD_ACK` (all three high), `ST_RD_DROP` (enable dropped).
- Write path: `ST_WR_XCV` (enable), `ST_WR_STB` (enable and strobe), `ST_WR_DROP` (strobe only), `ST_WR_ACK` (strobe and acknowledge).
- `ST_RELEASE`: outputs low, waiting for the device acknowledge to fall.

Transitions:
- From `ST_IDLE`, a lone read strobe goes to `ST_RD_STB` and a lone write strobe goes to `ST_WR_XCV`. In safe mode either move also needs the acknowledge to be low.
- `ST_RD_STB` goes to `ST_RD_XCV` when the acknowledge is high and the phase bit is set.
- `ST_RD_XCV` goes to `ST_RD_ACK` unconditionally.
- `ST_RD_ACK` goes to `ST_RD_DROP` when the read strobe is low.
- `ST_WR_XCV` goes to `ST_WR_STB` unconditionally.
- `ST_WR_STB` goes to `ST_WR_DROP` when the acknowledge is high.
- `ST_WR_DROP` goes to `ST_WR_ACK` unconditionally.
- `ST_WR_ACK` leaves when the write strobe is low.
- `ST_RD_DROP` and `ST_WR_ACK` go to `ST_RELEASE` in safe mode and to `ST_IDLE` in fast mode.
- `ST_RELEASE` goes to `ST_IDLE` when the acknowledge is low.

Top module: `bushs_ctrl`

## Requirements
- R1: Synchronous reset (rst_n low at a clock edge) forces idle: device strobe, transceiver enable, bus acknowledge and error all 0, and the phase bit cleared. This holds even in the middle of a cycle.
- R2: Read ordering. The device strobe rises first. After the device acknowledge, the transceiver enable rises, and one clock later the bus acknowledge rises while the enable is still high.
- R3: Read release. SYNC_STAGES+1 clocks after the read strobe falls, the transceiver enable falls. On the next clock the device strobe and the bus acknowledge fall together.
- R4: Write ordering. The transceiver enable rises first and the device strobe follows one clock later. After the device acknowledge, the enable falls, and one clock later the bus acknowledge rises while the enable is low.
- R5: Write release. SYNC_STAGES+1 clocks after the write strobe falls, the device strobe and the bus acknowledge fall together.
- R6: An input change is acted on at the (SYNC_STAGES+1)-th rising edge after it. With the default of 2 stages, no output moves at the 2nd edge and the response appears at the 3rd.
- R7: In any one clock at most one output changes. The only exception is the device strobe and the bus acknowledge falling together while the enable holds.
- R8: In safe mode, a strobe that arrives while the device acknowledge is still high is held. No output rises until the acknowledge has been low. The cycle then starts one clock after the machine leaves release, and no error is raised.
- R9: In fast mode, a strobe that rises in idle while the device acknowledge is high starts the cycle: the device strobe rises at the usual latency. The error output rises at the same edge.
- R10: If both master strobes are high together, the error is raised and neither cycle is started (outputs stay 0).
- R11: A device acknowledge that rises while the device strobe is low raises the error.
- R12: A master strobe that falls during its cycle before the bus acknowledge is high raises the error.
- R13: The error output stays high once set, through later cycles and input changes, until reset.
- R14: In a read, the transceiver enable rises only after the device acknowledge has been seen low and then high since the read strobe rose. A stale acknowledge still high from the last cycle leaves the enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_strobe_i | input | 1 | Master read request strobe (asynchronous) |
| wr_strobe_i | input | 1 | Master write request strobe (asynchronous) |
| dev_ack_i | input | 1 | Local device acknowledge (asynchronous) |
| dev_strobe_o | output | 1 | Local device strobe |
| xcvr_en_o | output | 1 | Data transceiver enable |
| bus_ack_o | output | 1 | Acknowledge back to the bus master |
| proto_err_o | output | 1 | Sticky protocol-violation flag |

## Verification
A safe-mode and a fast-mode instance receive the same stimulus, so every pattern shows where the two end-of-cycle policies agree and where they part. The bench runs read and write cycles in a sweep of alternating and repeated kinds with varied idle gaps, sampling each output step at its exact edge. This separates the two orderings and checks the synchroniser latency. A request issued while the device acknowledge is still high distinguishes safe holding from fast acceptance with the phase-bit guard. Double strobes, a spurious acknowledge and early strobe withdrawal each confirm that the error flag sets, holds and clears only by reset.

// File: rtl/bushs_pkg.sv
package bushs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_STB,
        ST_RD_XCV,
        ST_RD_ACK,
        ST_RD_DROP,
        ST_WR_XCV,
        ST_WR_STB,
        ST_WR_DROP,
        ST_WR_ACK,
        ST_RELEASE
    } hs_state_e;

    typedef enum logic [1:0] {
        CK_NONE,
        CK_READ,
        CK_WRITE
    } hs_kind_e;

    typedef struct packed {
        logic lds;
        logic xcv;
        logic ack;
    } hs_out_t;

    // Output vector held in each state.
    function automatic hs_out_t hs_decode(hs_state_e s);
        hs_out_t o;
        o = '0;
        unique case (s)
            ST_RD_STB:  o = '{lds: 1'b1, xcv: 1'b0, ack: 1'b0};
            ST_RD_XCV:  o = '{lds: 1'b1, xcv: 1'b1, ack: 1'b0};
            ST_RD_ACK:  o = '{lds: 1'b1, xcv: 1'b1, ack: 1'b1};
            ST_RD_DROP: o = '{lds: 1'b1, xcv: 1'b0, ack: 1'b1};
            ST_WR_XCV:  o = '{lds: 1'b0, xcv: 1'b1, ack: 1'b0};
            ST_WR_STB:  o = '{lds: 1'b1, xcv: 1'b1, ack: 1'b0};
            ST_WR_DROP: o = '{lds: 1'b1, xcv: 1'b0, ack: 1'b0};
            ST_WR_ACK:  o = '{lds: 1'b1, xcv: 1'b0, ack: 1'b1};
            default:    o = '0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/bushs_sync.sv
module bushs_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d_i;
            for (int k = 1; k < STAGES; k++) begin
                chain_q[k] <= chain_q[k-1];
            end
        end
    end

    assign q_o = chain_q[LAST];

endmodule

// File: rtl/bushs_fsm.sv
module bushs_fsm
    import bushs_pkg::*;
#(
    parameter bit SAFE_MODE = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rd_s,
    input  logic     wr_s,
    input  logic     ack_s,
    output hs_out_t  outs_o,
    output hs_kind_e kind_o,
    output logic     idle_o
);
    hs_state_e state_q, state_d;
    hs_state_e end_target;
    hs_out_t   outs_q;
    logic      start_ok;
    logic      phase_q;

    // Mode variant: where a finished cycle goes and when idle may accept.
    generate
        if (SAFE_MODE) begin : g_safe
            assign end_target = ST_RELEASE;
            assign start_ok   = !ack_s;
        end else begin : g_fast
            assign end_target = ST_IDLE;
            assign start_ok   = 1'b1;
        end
    endgenerate

    // Phase bit: set once the acknowledge is seen low under a read request.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= rd_s & (phase_q | !ack_s);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_ok && rd_s && !wr_s)      state_d = ST_RD_STB;
                else if (start_ok && wr_s && !rd_s) state_d = ST_WR_XCV;
            end
            ST_RD_STB:  if (ack_s && phase_q) state_d = ST_RD_XCV;
            ST_RD_XCV:  state_d = ST_RD_ACK;
            ST_RD_ACK:  if (!rd_s) state_d = ST_RD_DROP;
            ST_RD_DROP: state_d = end_target;
            ST_WR_XCV:  state_d = ST_WR_STB;
            ST_WR_STB:  if (ack_s) state_d = ST_WR_DROP;
            ST_WR_DROP: state_d = ST_WR_ACK;
            ST_WR_ACK:  if (!wr_s) state_d = end_target;
            ST_RELEASE: if (!ack_s) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register, loaded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) outs_q <= '0;
        else        outs_q <= hs_decode(state_d);
    end

    always_comb begin
        unique case (state_q)
            ST_RD_STB, ST_RD_XCV, ST_RD_ACK, ST_RD_DROP: kind_o = CK_READ;
            ST_WR_XCV, ST_WR_STB, ST_WR_DROP, ST_WR_ACK: kind_o = CK_WRITE;
            default:                                     kind_o = CK_NONE;
        endcase
    end

    assign outs_o = outs_q;
    assign idle_o = (state_q == ST_IDLE);

    logic [2:0] ov;
    assign ov = outs_q;

    assert_single_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(ov ^ $past(ov)) <= 1) ||
        ($fell(outs_q.lds) && $fell(outs_q.ack) && $stable(outs_q.xcv)))
        else $error("R7 more than one handshake step in a clock");

    assert_read_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_o == CK_READ && $rose(outs_q.ack)) |-> outs_q.xcv)
        else $error("R2 read acknowledge without transceiver enable");

    assert_write_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_o == CK_WRITE && $rose(outs_q.ack)) |-> !outs_q.xcv)
        else $error("R4 write acknowledge with transceiver enable high");

    assert_phase_guard_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_o == CK_READ && outs_q.xcv) |-> phase_q)
        else $error("R14 read enable without a fresh acknowledge");

endmodule

// File: rtl/bushs_errmon.sv
module bushs_errmon
    import bushs_pkg::*;
#(
    parameter bit SAFE_MODE = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rd_s,
    input  logic     wr_s,
    input  logic     ack_s,
    input  logic     lds,
    input  logic     bus_ack,
    input  hs_kind_e kind,
    input  logic     idle,
    output logic     err_o
);
    logic rd_d, wr_d, ack_d, err_q;
    logic both_hi, stale_ack, spur_ack, early_drop, lost_ack;
    logic strobe_rise;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_d  <= 1'b0;
            wr_d  <= 1'b0;
            ack_d <= 1'b0;
        end else begin
            rd_d  <= rd_s;
            wr_d  <= wr_s;
            ack_d <= ack_s;
        end
    end

    assign strobe_rise = (rd_s & !rd_d) | (wr_s & !wr_d);
    assign both_hi     = rd_s & wr_s;
    assign spur_ack    = ack_s & !ack_d & !lds;
    assign lost_ack    = ack_d & !ack_s & lds;
    assign early_drop  = ((kind == CK_READ)  & rd_d & !rd_s & !bus_ack) |
                         ((kind == CK_WRITE) & wr_d & !wr_s & !bus_ack);

    generate
        if (SAFE_MODE) begin : g_safe
            assign stale_ack = 1'b0;
        end else begin : g_fast
            assign stale_ack = idle & strobe_rise & ack_s;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else if (both_hi | stale_ack | spur_ack | lost_ack | early_drop) err_q <= 1'b1;
    end

    assign err_o = err_q;

    assert_err_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_q) |-> err_q)
        else $error("R13 error flag dropped without reset");

endmodule

// File: rtl/bushs_ctrl.sv
module bushs_ctrl
    import bushs_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter bit SAFE_MODE   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_strobe_i,
    input  logic wr_strobe_i,
    input  logic dev_ack_i,
    output logic dev_strobe_o,
    output logic xcvr_en_o,
    output logic bus_ack_o,
    output logic proto_err_o
);
    localparam int NIN = 3;

    logic [NIN-1:0] raw_in, sync_in;
    hs_out_t        outs;
    hs_kind_e       kind;
    logic           idle;

    assign raw_in = {rd_strobe_i, wr_strobe_i, dev_ack_i};

    bushs_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (sync_in)
    );

    bushs_fsm #(.SAFE_MODE(SAFE_MODE)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_s   (sync_in[2]),
        .wr_s   (sync_in[1]),
        .ack_s  (sync_in[0]),
        .outs_o (outs),
        .kind_o (kind),
        .idle_o (idle)
    );

    bushs_errmon #(.SAFE_MODE(SAFE_MODE)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_s    (sync_in[2]),
        .wr_s    (sync_in[1]),
        .ack_s   (sync_in[0]),
        .lds     (outs.lds),
        .bus_ack (outs.ack),
        .kind    (kind),
        .idle    (idle),
        .err_o   (proto_err_o)
    );

    assign dev_strobe_o = outs.lds;
    assign xcvr_en_o    = outs.xcv;
    assign bus_ack_o    = outs.ack;

endmodule

// File: tb/bushs_ctrl_tb_top.sv
module bushs_ctrl_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd = 1'b0, wr = 1'b0, ack = 1'b0;
    logic s_lds, s_xcv, s_ack, s_err;
    logic f_lds, f_xcv, f_ack, f_err;
    int   n_chk = 0;
    int   n_fail = 0;

    always #5 clk = ~clk;

    bushs_ctrl #(.SYNC_STAGES(2), .SAFE_MODE(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .rd_strobe_i(rd), .wr_strobe_i(wr), .dev_ack_i(ack),
        .dev_strobe_o(s_lds), .xcvr_en_o(s_xcv), .bus_ack_o(s_ack), .proto_err_o(s_err));

    bushs_ctrl #(.SYNC_STAGES(2), .SAFE_MODE(1'b0)) dut_fast_i (
        .clk(clk), .rst_n(rst_n), .rd_strobe_i(rd), .wr_strobe_i(wr), .dev_ack_i(ack),
        .dev_strobe_o(f_lds), .xcvr_en_o(f_xcv), .bus_ack_o(f_ack), .proto_err_o(f_err));

    // Advance n rising edges, then stop on the following falling edge.
    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Expected vectors are {dev_strobe, xcvr_en, bus_ack, error}.
    task automatic chk2(input string tag, input logic [3:0] exp_s, input logic [3:0] exp_f);
        logic [3:0] as, af;
        as = {s_lds, s_xcv, s_ack, s_err};
        af = {f_lds, f_xcv, f_ack, f_err};
        n_chk++;
        if (as !== exp_s) begin
            n_fail++;
            $display("FAIL %s safe actual=%b expected=%b", tag, as, exp_s);
        end
        n_chk++;
        if (af !== exp_f) begin
            n_fail++;
            $display("FAIL %s fast actual=%b expected=%b", tag, af, exp_f);
        end
    endtask

    task automatic pulse_reset();
        rd = 1'b0; wr = 1'b0; ack = 1'b0;
        rst_n = 1'b0;
        edges(2);
        rst_n = 1'b1;
        edges(3);
        chk2("R1 after reset", 4'b0000, 4'b0000);
    endtask

    task automatic run_read(input bit drop_ack);
        rd = 1'b1;
        edges(2); chk2("R6 read not yet seen", 4'b0000, 4'b0000);
        edges(1); chk2("R2 read strobe first", 4'b1000, 4'b1000);
        ack = 1'b1;
        edges(2); chk2("R6 ack not yet seen", 4'b1000, 4'b1000);
        edges(1); chk2("R2 read enable", 4'b1100, 4'b1100);
        edges(1); chk2("R2 read bus ack", 4'b1110, 4'b1110);
        rd = 1'b0;
        edges(3); chk2("R3 read enable drop", 4'b1010, 4'b1010);
        edges(1); chk2("R3 read joint release", 4'b0000, 4'b0000);
        if (drop_ack) begin
            ack = 1'b0;
            edges(4);
        end
    endtask

    task automatic run_write();
        wr = 1'b1;
        edges(3); chk2("R4 write enable first", 4'b0100, 4'b0100);
        edges(1); chk2("R4 write strobe next", 4'b1100, 4'b1100);
        ack = 1'b1;
        edges(3); chk2("R4 write enable drop", 4'b1000, 4'b1000);
        edges(1); chk2("R4 write bus ack", 4'b1010, 4'b1010);
        wr = 1'b0;
        edges(2); chk2("R5 write hold", 4'b1010, 4'b1010);
        edges(1); chk2("R5 write joint release", 4'b0000, 4'b0000);
        ack = 1'b0;
        edges(4);
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        edges(3);
        chk2("R1 in reset", 4'b0000, 4'b0000);
        rst_n = 1'b1;
        edges(3);
        chk2("R1 after release", 4'b0000, 4'b0000);

        // Sweep of cycle kinds with varied idle gaps.
        for (int i = 0; i < 9; i++) begin
            if ((i % 3) == 1) run_write();
            else run_read(1'b1);
            edges(i % 4);
            chk2("R1 idle between cycles", 4'b0000, 4'b0000);
        end

        // Stale acknowledge: R8 safe hold, R9 fast accept, R14 phase guard.
        run_read(1'b0);
        edges(2);
        rd = 1'b1;
        edges(3); chk2("R9 stale ack start", 4'b0000, 4'b1001);
        edges(7); chk2("R8 R14 stale ack hold", 4'b0000, 4'b1001);
        ack = 1'b0;
        edges(3); chk2("R8 release exit", 4'b0000, 4'b1001);
        edges(1); chk2("R8 held cycle starts", 4'b1000, 4'b1001);
        edges(2);
        ack = 1'b1;
        edges(3); chk2("R14 fresh ack enable", 4'b1100, 4'b1101);
        edges(1); chk2("R2 bus ack after fresh ack", 4'b1110, 4'b1111);
        rd = 1'b0;
        edges(4); chk2("R3 R13 release", 4'b0000, 4'b0001);
        ack = 1'b0;
        edges(4); chk2("R13 error held", 4'b0000, 4'b0001);
        pulse_reset();

        // R10 both strobes.
        rd = 1'b1; wr = 1'b1;
        edges(2); chk2("R10 not yet seen", 4'b0000, 4'b0000);
        edges(1); chk2("R10 both strobes error", 4'b0001, 4'b0001);
        edges(5); chk2("R10 no cycle served", 4'b0001, 4'b0001);
        rd = 1'b0; wr = 1'b0;
        edges(4); chk2("R13 error sticky", 4'b0001, 4'b0001);
        pulse_reset();

        // R11 spurious acknowledge.
        ack = 1'b1;
        edges(2); chk2("R11 not yet seen", 4'b0000, 4'b0000);
        edges(1); chk2("R11 spurious ack error", 4'b0001, 4'b0001);
        ack = 1'b0;
        edges(4); chk2("R13 error after ack drop", 4'b0001, 4'b0001);
        pulse_reset();

        // R12 early strobe withdrawal, read then write.
        rd = 1'b1;
        edges(3); chk2("R12 read started", 4'b1000, 4'b1000);
        rd = 1'b0;
        edges(2); chk2("R12 drop not yet seen", 4'b1000, 4'b1000);
        edges(1); chk2("R12 early read drop", 4'b1001, 4'b1001);
        pulse_reset();
        wr = 1'b1;
        edges(4); chk2("R12 write started", 4'b1100, 4'b1100);
        wr = 1'b0;
        edges(3); chk2("R12 early write drop", 4'b1101, 4'b1101);
        pulse_reset();

        // Normal cycle after all error tests.
        run_write();
        chk2("R5 clean after reset", 4'b0000, 4'b0000);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule